// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block keeps the single reservation used by atomic read-modify-write sequences. A reserve-load request, when aligned, issues a read to memory and records its effective address as the reservation. A later conditional store either proceeds or is refused. It proceeds only when a valid reservation is held for the same effective address. In both cases the block reports the outcome in a 4-bit condition field.

Word and doubleword forms use the same reservation and the same alignment rule. In 32-bit address mode, the upper half of the address is discarded. This happens both when the address is recorded and when it is compared. An external snoop-invalidate, any conditional store and reset all drop the reservation. The memory array and the exception logic that consumes the alignment fault sit outside this block. Every output is registered and appears one cycle after the request is presented.

Top module: `lrsc_monitor`

## Requirements
- R1: A request whose address bits [1:0] are not both zero pulses `align_fault` in the next cycle. It produces no read, no write and no condition result, and leaves the reservation unchanged.
- R2: An aligned reserve-load (`req_store`=0) pulses `mem_rd_en` in the next cycle, with `mem_addr` set to the effective address. It also makes `resv_valid` 1.
- R3: When `mode64`=0, the effective address is `addr[31:0]` zero-extended, and only the low 32 bits take part in the reservation compare. When `mode64`=1, all 64 bits are used.
- R4: An aligned conditional store that fails produces no write. It pulses `cond_valid` with `cond_field` = {0,0,0,so}, where bit 0 copies `so_in` and bit 1 is the success flag.
- R5: An aligned conditional store with a valid, matching reservation pulses `mem_wr_en`. `mem_addr` carries the effective address and `mem_wdata` carries `wdata`. `cond_field` = {0,0,1,so}.
- R6: Word and doubleword forms share one reservation. `mem_dword` follows `req_dword` for the issued access.
- R7: After any aligned conditional store, whether it succeeds or fails, `resv_valid` is 0.
- R8: `snoop_inv` clears the reservation. A conditional store in the same cycle as a snoop fails. A reserve-load in the same cycle as a snoop sets a new reservation.
- R9: A conditional store with no valid reservation fails, even when its address equals the last recorded address.
- R10: During and directly after reset, all outputs are 0.
- R11: In a cycle following no request, all strobes are 0, and `mem_addr`, `mem_wdata` and `cond_field` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 0 reserve-load, 1 conditional store |
| req_dword | input | 1 | 0 word, 1 doubleword |
| mode64 | input | 1 | 1 selects 64-bit addressing |
| addr | input | 64 | Request address |
| wdata | input | 64 | Store data |
| so_in | input | 1 | Current summary-overflow flag |
| snoop_inv | input | 1 | External reservation kill |
| resv_valid | output | 1 | Reservation held |
| align_fault | output | 1 | Misaligned request pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_dword | output | 1 | Access size of the issued access |
| mem_addr | output | 64 | Effective address of the issued access |
| mem_wdata | output | 64 | Write data |
| cond_valid | output | 1 | Condition result pulse |
| cond_field | output | 4 | Condition field: bit1 success, bit0 overflow copy |

## Verification
The assertions check several rules on every cycle:
- misalignment suppresses all memory traffic;
- every conditional store leaves the reservation invalid;
- a snoop without a same-cycle reserve-load kills the reservation;
- the success flag and the write strobe always agree;
- the overflow copy follows `so_in`;
- a store without a reservation never writes.

Some behaviour only the bench can show. This covers the address compare itself: 32-bit truncation that makes addresses with different upper halves match, and mismatches in 64-bit mode. It also covers the exact effective address and data driven to memory, and the sharing of one reservation across word and doubleword forms. The bench shows these through sweeps over mode, size, alignment, overflow and upper-address patterns, plus a long pseudo-random request stream checked against an arithmetic model.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic          req_dword,
  input  logic          mode64,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          so_in,
  input  logic          snoop_inv,
  output logic          resv_valid,
  output logic          align_fault,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          mem_dword,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cond_valid,
  output logic [3:0]    cond_field
);
  localparam int HW = AW - NW;

  logic [AW-1:0] resv_addr;

  wire          aligned = (addr[1:0] == 2'b00);
  wire [AW-1:0] eff     = mode64 ? addr : {{HW{1'b0}}, addr[NW-1:0]};
  wire          match   = mode64 ? (resv_addr == addr)
                                 : (resv_addr[NW-1:0] == addr[NW-1:0]);
  wire          do_load = req_valid & aligned & ~req_store;
  wire          do_sc   = req_valid & aligned &  req_store;
  wire          sc_ok   = do_sc & resv_valid & ~snoop_inv & match;
  wire          issue   = do_load | sc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid  <= 1'b0;
      resv_addr   <= '0;
      align_fault <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_dword   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      cond_valid  <= 1'b0;
      cond_field  <= '0;
    end else begin
      align_fault <= req_valid & ~aligned;
      mem_rd_en   <= do_load;
      mem_wr_en   <= sc_ok;
      mem_dword   <= issue & req_dword;
      mem_addr    <= issue ? eff : '0;
      mem_wdata   <= sc_ok ? wdata : '0;
      cond_valid  <= do_sc;
      cond_field  <= do_sc ? {2'b00, sc_ok, so_in} : 4'b0000;
      if (do_load) begin
        resv_valid <= 1'b1;
        resv_addr  <= eff;
      end else if (do_sc | snoop_inv) begin
        resv_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lrsc_monitor_props.sv
module lrsc_monitor_props #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_store,
  input logic [AW-1:0] addr,
  input logic          so_in,
  input logic          snoop_inv,
  input logic          resv_valid,
  input logic          align_fault,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic          cond_valid,
  input logic [3:0]    cond_field
);
  assert_misaligned_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr[1:0] != 2'b00) |=> (align_fault && !mem_rd_en && !mem_wr_en && !cond_valid));

  assert_load_reserves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && addr[1:0] == 2'b00) |=> (mem_rd_en && resv_valid));

  assert_overflow_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && addr[1:0] == 2'b00) |=> (cond_valid && cond_field[0] == $past(so_in) && cond_field[3:2] == 2'b00));

  assert_write_means_success_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> (mem_wr_en == cond_field[1]));

  assert_store_kills_resv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && addr[1:0] == 2'b00) |=> !resv_valid);

  assert_snoop_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_inv && !(req_valid && !req_store && addr[1:0] == 2'b00)) |=> !resv_valid);

  assert_no_resv_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !resv_valid) |=> !mem_wr_en);

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({align_fault, mem_rd_en, cond_valid}));
endmodule

bind lrsc_monitor lrsc_monitor_props #(.AW(AW)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .addr(addr), .so_in(so_in), .snoop_inv(snoop_inv), .resv_valid(resv_valid),
  .align_fault(align_fault), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .cond_valid(cond_valid), .cond_field(cond_field)
);

// File: tb/lrsc_monitor_bench.sv
`timescale 1ns/1ps
module lrsc_monitor_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_store = 0, req_dword = 0, mode64 = 0;
  logic [63:0] addr = 0, wdata = 0;
  logic        so_in = 0, snoop_inv = 0;
  logic        resv_valid, align_fault, mem_rd_en, mem_wr_en, mem_dword, cond_valid;
  logic [63:0] mem_addr, mem_wdata;
  logic [3:0]  cond_field;

  int checks = 0, failures = 0;
  logic        m_rv = 0;
  logic [63:0] m_ra = 0;

  always #2.5 clk = ~clk;

  lrsc_monitor u_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_dword(req_dword), .mode64(mode64), .addr(addr), .wdata(wdata),
    .so_in(so_in), .snoop_inv(snoop_inv), .resv_valid(resv_valid),
    .align_fault(align_fault), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_dword(mem_dword), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cond_valid(cond_valid), .cond_field(cond_field)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Drive one request at a falling edge, model it, check results one cycle later.
  task automatic step(input logic v, input logic st, input logic dw, input logic m64,
                      input logic [63:0] a, input logic [63:0] d, input logic so,
                      input logic sn, input string tag);
    logic [63:0] eff;
    logic al, ld, sc, ok, hit, iss;
    logic [9:0] e_flags;
    logic [63:0] e_addr, e_data;
    eff = m64 ? a : {32'h0, a[31:0]};
    al  = (a[1:0] == 2'b00);
    ld  = v && al && !st;
    sc  = v && al && st;
    hit = m64 ? (m_ra == a) : (m_ra[31:0] == a[31:0]);
    ok  = sc && m_rv && !sn && hit;
    iss = ld || ok;
    e_flags = {v && !al, ld, ok, iss && dw, sc, (sc ? {2'b00, ok, so} : 4'b0), 1'b0};
    e_addr  = iss ? eff : 64'h0;
    e_data  = ok ? d : 64'h0;
    if (ld) begin m_rv = 1; m_ra = eff; end
    else if (sc || sn) m_rv = 0;
    e_flags[0] = m_rv;
    req_valid = v; req_store = st; req_dword = dw; mode64 = m64;
    addr = a; wdata = d; so_in = so; snoop_inv = sn;
    @(negedge clk);
    req_valid = 0; snoop_inv = 0;
    chk({tag, " flags"}, {54'h0, align_fault, mem_rd_en, mem_wr_en, mem_dword, cond_valid,
                          cond_field, resv_valid}, {54'h0, e_flags});
    chk({tag, " mem_addr"}, mem_addr, e_addr);
    chk({tag, " mem_wdata"}, mem_wdata, e_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset and just after release
    chk("R10 in reset", {align_fault, mem_rd_en, mem_wr_en, cond_valid, cond_field, resv_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 after reset", {align_fault, mem_rd_en, mem_wr_en, mem_dword, cond_valid,
                            cond_field, resv_valid, mem_addr, mem_wdata}, 0);

    // Directed cases
    step(1, 1, 0, 1, 64'h100, 64'h11, 1, 0, "R9 store no resv");
    step(1, 0, 0, 1, 64'h200, 0, 0, 0, "R2 reserve");
    step(1, 1, 1, 1, 64'h208, 64'h22, 0, 0, "R4 mismatch");
    step(1, 1, 0, 1, 64'h200, 64'h33, 0, 0, "R9 stale match");
    step(1, 0, 0, 1, 64'h300, 0, 0, 0, "R6 reserve word");
    step(1, 1, 1, 1, 64'h300, 64'hDEAD_BEEF_0123_4567, 1, 0, "R6 store dword");
    step(1, 0, 0, 0, 64'hFFFF_0000_0000_0400, 0, 0, 0, "R3 reserve trunc");
    step(1, 1, 0, 0, 64'h1234_5678_0000_0400, 64'h44, 0, 0, "R3 match trunc");
    step(1, 0, 0, 1, 64'h500, 0, 0, 0, "R2 reserve");
    step(1, 1, 0, 1, 64'h502, 64'h55, 0, 0, "R1 misaligned store");
    step(1, 0, 1, 1, 64'h601, 0, 0, 0, "R1 misaligned load");
    step(1, 1, 0, 1, 64'h500, 64'h66, 0, 0, "R1 resv kept");
    step(0, 0, 0, 1, 64'h700, 0, 0, 0, "R11 idle");
    step(1, 0, 0, 1, 64'h700, 0, 0, 0, "R2 reserve");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R8 snoop");
    step(1, 1, 0, 1, 64'h700, 64'h77, 0, 0, "R8 after snoop");
    step(1, 0, 0, 1, 64'h800, 0, 0, 0, "R2 reserve");
    step(1, 1, 0, 1, 64'h800, 64'h88, 0, 1, "R8 store with snoop");
    step(1, 0, 0, 1, 64'h900, 0, 0, 1, "R8 load with snoop");
    step(1, 1, 0, 1, 64'h900, 64'h99, 1, 0, "R5 match");
    step(1, 1, 0, 1, 64'h900, 64'h99, 0, 0, "R7 second store");

    // Sweep: mode, size, overflow, alignment, upper-half pattern
    for (int m = 0; m < 2; m++)
      for (int dw = 0; dw < 2; dw++)
        for (int so = 0; so < 2; so++)
          for (int lo = 0; lo < 4; lo++)
            for (int hi = 0; hi < 2; hi++) begin
              logic [63:0] a, b;
              a = {(hi != 0) ? 32'hC0DE_0000 : 32'h0, 32'h0000_1000 | lo};
              b = {32'h0F0F_0000, a[31:0]};
              step(1, 0, dw[0], m[0], a, 0, so[0], 0, "R2 sweep reserve");
              step(1, 1, dw[0], m[0], b, {a[31:0], b[31:0]}, so[0], 0, "R3 sweep store");
              step(1, 1, !dw[0], m[0], a, 64'h5A, so[0], 0, "R7 sweep restore");
            end

    // Pseudo-random stream against the model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = {lfsr[9] ? 32'hA5A5_0000 : 32'h0, 24'h0, 3'b0, lfsr[11:10], (lfsr[12] && lfsr[13]) ? lfsr[15:14] : 2'b00};
      step(lfsr[0] | lfsr[1], lfsr[2], lfsr[3], lfsr[4] | lfsr[5], a,
           {lfsr, ~lfsr}, lfsr[6], lfsr[7] & lfsr[8] & lfsr[16], "R5 random");
    end
    summary();
  end
endmodule